// File: doc/BRIEF.md
# Rotating-Priority Interrupt Service Controller

This block arbitrates among eight interrupt request lines and tracks which levels are currently being serviced. A one-cycle pulse on a request input latches a pending request. When the host pulses the acknowledge input, the block grants the pending level with the highest priority. It marks that level as in service, clears its pending latch and returns its 3-bit vector number one cycle later.

The priority order is circular and is defined by a "lowest level" pointer: the level just after the pointer has the highest priority. Software changes the order and retires in-service levels by writing a single command byte. The byte can end service on a named level or on the highest level in service. It can turn automatic rotation on or off, or name the lowest-priority level directly. An automatic end-of-service input lets acknowledged levels skip the in-service register. When rotation is on, this input also moves each granted level to the bottom of the order.

Top module: `intsvc_ctrl`

## Requirements
- R1: After reset the in-service register is 0, the lowest-priority level is 7 (so level 0 is highest), automatic rotation is off, and intOut and vecValid are 0.
- R2: A write is a command only when wrData bits 4:3 are 00. The command code is {bit7, bit6, bit5}, and bits 2:0 hold a level L. A write with bits 4:3 at 01, 10 or 11 changes no in-service bit, rotation flag or priority order.
- R3: Priority rank is (level − lowest − 1) mod 8, where rank 0 is highest. An acknowledge grants the pending level of lowest rank. It sets that level's in-service bit and clears its request latch. It also drives the level on vecOut with vecValid high during the cycle after the acknowledge.
- R4: A pending level is not granted while a level of equal or higher priority is in service. In that case intOut is 0 and an acknowledge produces no vecValid.
- R5: Code 001 clears the in-service bit of the highest-priority level in service. With nothing in service it has no effect.
- R6: Code 011 clears the in-service bit of level L.
- R7: Code 010 changes nothing.
- R8: Code 100 turns automatic rotation on and code 000 turns it off. Neither code clears an in-service bit, and both ignore L.
- R9: Code 101 turns automatic rotation on and clears the highest-priority in-service bit. The level it clears becomes the lowest priority.
- R10: Code 110 makes L the lowest priority without clearing any in-service bit. Code 111 does the same and also clears the in-service bit of L.
- R11: While autoEoiEn is 1, a grant does not set an in-service bit. If automatic rotation is also on, the granted level becomes the lowest priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irqIn | input | 8 | Request pulses, one bit per level |
| wrEn | input | 1 | Command byte write strobe |
| wrData | input | 8 | Command byte |
| ackIn | input | 1 | Acknowledge strobe |
| autoEoiEn | input | 1 | Retire levels at grant time |
| intOut | output | 1 | A grantable request is pending |
| vecValid | output | 1 | vecOut carries a granted level |
| vecOut | output | 3 | Granted level number |
| isrOut | output | 8 | In-service register |
| lowestOut | output | 3 | Current lowest-priority level |
| rotateOn | output | 1 | Automatic rotation flag |

## Verification
A wrong lowest-priority pointer changes which level the next acknowledge grants, so it shows on vecOut one cycle after that acknowledge. It is also visible on lowestOut right after the write that set it. A stale or wrongly cleared in-service bit appears on isrOut in the cycle after the command. It then shows as intOut staying low, or as an extra grant, on the following acknowledge. The bench queues each expected vector before it acknowledges, so a misordered or missing grant is caught on the next edge.

// File: rtl/intsvc_pkg.sv
package intsvc_pkg;
  localparam int NUM_LEVELS = 8;
  localparam int LVL_W = $clog2(NUM_LEVELS);

  typedef struct packed {
    logic nsEoi;
    logic specEoi;
    logic rotSet;
    logic rotClr;
    logic specRot;
    logic rotOnEoi;
    logic [LVL_W-1:0] level;
  } cmdStrobe_t;

  // Returns {found, rank} of the first set bit scanning from lowest+1 upward.
  function automatic logic [LVL_W:0] scanRank(input logic [NUM_LEVELS-1:0] v,
                                              input logic [LVL_W-1:0] low);
    logic [LVL_W-1:0] lvl;
    scanRank = '0;
    for (int k = NUM_LEVELS - 1; k >= 0; k--) begin
      lvl = low + LVL_W'(k) + LVL_W'(1);
      if (v[lvl]) scanRank = {1'b1, LVL_W'(k)};
    end
  endfunction
endpackage

// File: rtl/intsvc_decode.sv
module intsvc_decode
  import intsvc_pkg::*;
(
  input  logic       wrEn,
  input  logic [7:0] wrData,
  output cmdStrobe_t strobe
);
  logic selHit;
  logic [2:0] code;

  assign selHit = wrEn && (wrData[4:3] == 2'b00);
  assign code = wrData[7:5];

  always_comb begin
    strobe = '0;
    strobe.level = wrData[LVL_W-1:0];
    if (selHit) begin
      case (code)
        3'b000: strobe.rotClr = 1'b1;
        3'b001: strobe.nsEoi = 1'b1;
        3'b011: strobe.specEoi = 1'b1;
        3'b100: strobe.rotSet = 1'b1;
        3'b101: begin
          strobe.rotSet = 1'b1;
          strobe.nsEoi = 1'b1;
          strobe.rotOnEoi = 1'b1;
        end
        3'b110: strobe.specRot = 1'b1;
        3'b111: begin
          strobe.specRot = 1'b1;
          strobe.specEoi = 1'b1;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/intsvc_core.sv
module intsvc_core
  import intsvc_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_LEVELS-1:0] irqIn,
  input  logic                  ackIn,
  input  logic                  autoEoiEn,
  input  cmdStrobe_t            strobe,
  output logic                  intOut,
  output logic                  vecValid,
  output logic [LVL_W-1:0]      vecOut,
  output logic [NUM_LEVELS-1:0] isrOut,
  output logic [LVL_W-1:0]      lowestOut,
  output logic                  rotateOn
);
  logic [NUM_LEVELS-1:0] irrQ, isrQ, clrMask, setMask, grantMask;
  logic [LVL_W-1:0] lowestQ, reqRank, isrRank, reqLvl, isrLvl;
  logic reqHit, isrHit, grantOk, grant, rotQ;

  assign {reqHit, reqRank} = scanRank(irrQ, lowestQ);
  assign {isrHit, isrRank} = scanRank(isrQ, lowestQ);
  assign reqLvl = lowestQ + reqRank + LVL_W'(1);
  assign isrLvl = lowestQ + isrRank + LVL_W'(1);

  assign grantOk = reqHit && (!isrHit || (reqRank < isrRank));
  assign grant = ackIn && grantOk;

  always_comb begin
    grantMask = '0;
    setMask = '0;
    clrMask = '0;
    if (grant) grantMask[reqLvl] = 1'b1;
    if (grant && !autoEoiEn) setMask[reqLvl] = 1'b1;
    if (strobe.nsEoi && isrHit) clrMask[isrLvl] = 1'b1;
    if (strobe.specEoi) clrMask[strobe.level] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irrQ <= '0;
      isrQ <= '0;
      lowestQ <= LVL_W'(NUM_LEVELS - 1);
      rotQ <= 1'b0;
      vecValid <= 1'b0;
      vecOut <= '0;
    end else begin
      irrQ <= (irrQ & ~grantMask) | irqIn;
      isrQ <= (isrQ & ~clrMask) | setMask;
      if (strobe.rotSet) rotQ <= 1'b1;
      else if (strobe.rotClr) rotQ <= 1'b0;
      if (strobe.specRot) lowestQ <= strobe.level;
      else if (strobe.rotOnEoi && isrHit) lowestQ <= isrLvl;
      else if (grant && autoEoiEn && rotQ) lowestQ <= reqLvl;
      vecValid <= grant;
      if (grant) vecOut <= reqLvl;
    end
  end

  assign intOut = grantOk;
  assign isrOut = isrQ;
  assign lowestOut = lowestQ;
  assign rotateOn = rotQ;
endmodule

// File: rtl/intsvc_ctrl.sv
module intsvc_ctrl
  import intsvc_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_LEVELS-1:0] irqIn,
  input  logic                  wrEn,
  input  logic [7:0]            wrData,
  input  logic                  ackIn,
  input  logic                  autoEoiEn,
  output logic                  intOut,
  output logic                  vecValid,
  output logic [LVL_W-1:0]      vecOut,
  output logic [NUM_LEVELS-1:0] isrOut,
  output logic [LVL_W-1:0]      lowestOut,
  output logic                  rotateOn
);
  cmdStrobe_t strobe;

  intsvc_decode decode_i (
    .wrEn(wrEn), .wrData(wrData), .strobe(strobe)
  );

  intsvc_core core_i (
    .clk(clk), .rst_n(rst_n), .irqIn(irqIn), .ackIn(ackIn),
    .autoEoiEn(autoEoiEn), .strobe(strobe), .intOut(intOut),
    .vecValid(vecValid), .vecOut(vecOut), .isrOut(isrOut),
    .lowestOut(lowestOut), .rotateOn(rotateOn)
  );
endmodule

// File: rtl/intsvc_ctrl_chk.sv
module intsvc_ctrl_chk
  import intsvc_pkg::*;
(
  input logic                  clk,
  input logic                  rst_n,
  input logic [NUM_LEVELS-1:0] irqIn,
  input logic                  wrEn,
  input logic [7:0]            wrData,
  input logic                  ackIn,
  input logic                  autoEoiEn,
  input logic                  intOut,
  input logic                  vecValid,
  input logic [LVL_W-1:0]      vecOut,
  input logic [NUM_LEVELS-1:0] isrOut,
  input logic [LVL_W-1:0]      lowestOut,
  input logic                  rotateOn
);
  p_bad_select_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wrEn && wrData[4:3] != 2'b00 && !ackIn)
    |=> ($stable(isrOut) && $stable(lowestOut) && $stable(rotateOn)));

  p_grant_sets_isr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ackIn && intOut && !autoEoiEn && !wrEn) |=> (vecValid && isrOut[vecOut]));

  p_no_grant_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ackIn && !intOut) |=> !vecValid);

  p_spec_eoi_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wrEn && wrData[4:3] == 2'b00 && wrData[7:5] == 3'b011 && !ackIn)
    |=> !isrOut[$past(wrData[2:0])]);

  p_nop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wrEn && wrData[7:3] == 5'b01000 && !ackIn)
    |=> ($stable(isrOut) && $stable(lowestOut) && $stable(rotateOn)));

  p_rot_on_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wrEn && wrData[7:3] == 5'b10000) |=> rotateOn);

  p_spec_rot_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wrEn && wrData[7:6] == 2'b11 && wrData[4:3] == 2'b00)
    |=> (lowestOut == $past(wrData[2:0])));

  p_auto_eoi_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (ackIn && intOut && autoEoiEn && !wrEn) |=> (vecValid && !isrOut[vecOut]));
endmodule

bind intsvc_ctrl intsvc_ctrl_chk chk_i (.*);

// File: tb/intsvc_ctrl_tb_top.sv
module intsvc_ctrl_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] irqIn = '0;
  logic wrEn = 1'b0;
  logic [7:0] wrData = '0;
  logic ackIn = 1'b0;
  logic autoEoiEn = 1'b0;
  logic intOut, vecValid, rotateOn;
  logic [2:0] vecOut, lowestOut;
  logic [7:0] isrOut;

  int total = 0;
  int bad = 0;
  logic [2:0] expQ[$];

  always #5 clk = ~clk;

  intsvc_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .irqIn(irqIn), .wrEn(wrEn), .wrData(wrData),
    .ackIn(ackIn), .autoEoiEn(autoEoiEn), .intOut(intOut), .vecValid(vecValid),
    .vecOut(vecOut), .isrOut(isrOut), .lowestOut(lowestOut), .rotateOn(rotateOn)
  );

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Monitor: compares each produced vector with the queued expectation.
  always @(negedge clk) begin
    if (rst_n && vecValid) begin
      total++;
      if (expQ.size() == 0) begin
        bad++;
        $display("FAIL R3/R4 unexpected grant actual=%0d expected=none", vecOut);
      end else begin
        logic [2:0] e;
        e = expQ.pop_front();
        if (vecOut != e) begin
          bad++;
          $display("FAIL R3 vector actual=%0d expected=%0d", vecOut, e);
        end
      end
    end
  end

  task automatic doReset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wrCmd(input logic [7:0] b);
    @(negedge clk);
    wrEn = 1'b1;
    wrData = b;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic pulseIrq(input logic [7:0] m);
    @(negedge clk);
    irqIn = m;
    @(negedge clk);
    irqIn = '0;
  endtask

  task automatic doAck(input bit expectGrant, input logic [2:0] lvl);
    if (expectGrant) expQ.push_back(lvl);
    @(negedge clk);
    ackIn = 1'b1;
    @(negedge clk);
    ackIn = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    #1_000_000;
    total++;
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    doReset();
    @(negedge clk);
    chk("R1 isr", isrOut, 8'h00);
    chk("R1 lowest", lowestOut, 7);
    chk("R1 rotate", rotateOn, 0);
    chk("R1 vecValid", vecValid, 0);
    chk("R1 intOut", intOut, 0);

    // R3: fixed order, level 3 beats 5
    pulseIrq(8'h28);
    chk("R3 intOut", intOut, 1);
    doAck(1, 3'd3);
    chk("R3 isr", isrOut, 8'h08);
    // R4: lower and equal priority blocked
    pulseIrq(8'h08);
    chk("R4 intOut", intOut, 0);
    doAck(0, 3'd0);
    chk("R4 isr kept", isrOut, 8'h08);
    // R5 nonspecific EOI
    wrCmd(8'h20);
    chk("R5 isr", isrOut, 8'h00);
    doAck(1, 3'd3);
    chk("R3 regrant isr", isrOut, 8'h08);
    // R6 specific EOI on level 3
    wrCmd(8'h63);
    chk("R6 isr", isrOut, 8'h00);
    doAck(1, 3'd5);
    chk("R3 isr5", isrOut, 8'h20);
    // R2 other selects ignored
    wrCmd(8'h28);
    chk("R2 sel01 isr", isrOut, 8'h20);
    wrCmd(8'h30);
    chk("R2 sel10 isr", isrOut, 8'h20);
    wrCmd(8'hF2);
    chk("R2 sel10 lowest", lowestOut, 7);
    // R7 nop
    wrCmd(8'h45);
    chk("R7 isr", isrOut, 8'h20);
    chk("R7 lowest", lowestOut, 7);
    chk("R7 rotate", rotateOn, 0);
    // R6 clear level 5
    wrCmd(8'h65);
    chk("R6 isr5", isrOut, 8'h00);
    // R5 with nothing in service
    wrCmd(8'h20);
    chk("R5 empty isr", isrOut, 8'h00);
    chk("R5 empty lowest", lowestOut, 7);
    // R8 rotation on/off, L ignored
    wrCmd(8'h85);
    chk("R8 rotate on", rotateOn, 1);
    chk("R8 lowest", lowestOut, 7);
    wrCmd(8'h03);
    chk("R8 rotate off", rotateOn, 0);
    chk("R8 lowest off", lowestOut, 7);
    // R10 specific rotation
    wrCmd(8'hC3);
    chk("R10 lowest", lowestOut, 3);
    pulseIrq(8'h14);
    doAck(1, 3'd4);
    chk("R10 isr", isrOut, 8'h10);
    wrCmd(8'hE4);
    chk("R10 lowest 111", lowestOut, 4);
    chk("R10 isr 111", isrOut, 8'h00);
    doAck(1, 3'd2);
    chk("R10 isr2", isrOut, 8'h04);
    // R9 rotate on nonspecific EOI
    wrCmd(8'hA0);
    chk("R9 isr", isrOut, 8'h00);
    chk("R9 lowest", lowestOut, 2);
    chk("R9 rotate", rotateOn, 1);

    // R11 automatic end of service
    doReset();
    autoEoiEn = 1'b1;
    wrCmd(8'h80);
    pulseIrq(8'h40);
    doAck(1, 3'd6);
    chk("R11 isr", isrOut, 8'h00);
    chk("R11 lowest", lowestOut, 6);
    wrCmd(8'h00);
    pulseIrq(8'h02);
    doAck(1, 3'd1);
    chk("R11 norot isr", isrOut, 8'h00);
    chk("R11 norot lowest", lowestOut, 6);
    autoEoiEn = 1'b0;

    repeat (2) @(negedge clk);
    chk("R3 queue drained", expQ.size(), 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule